// File: doc/BRIEF.md
# External Edge Interrupt Request Controller

This block turns a set of external interrupt pins into latched interrupt request flags. Each pin is brought into the clock domain through a short synchroniser. A change of level is then detected, and it counts only when the new level matches the polarity chosen for that pin. The low request slots belong to their pins alone. Each of the upper slots is shared with an on-chip peripheral event, and a per-slot select bit decides which of the two sources may set the slot's flag. Where two peripheral events share a slot, the system combines them into one event pulse before it reaches the block.

Software works through a small 32-bit register port. The port holds the polarity bits, the select bits, the enable bits and the request flags. A flag can be cleared by writing 0 to it, or by an acknowledge pulse from the interrupt controller. Each slot drives its own request line, which is high when the slot's flag and enable bit are both set. After software changes a select bit, it must clear that slot's flag before it enables the slot, because a request left by the previous source stays latched. A build parameter removes the three highest pins for smaller packages. Those slots then serve only their peripheral source.

Top module: `extirq_top`

## Requirements
- R1: After reset the polarity, select, enable and flag registers all read 0, every request line is low, and every shared slot listens to its peripheral source.
- R2: A pin edge in the selected direction sets the slot flag on the third rising clock edge after the pin changes. Polarity bit 1 selects a rising edge and 0 selects a falling edge. A change in the other direction sets nothing.
- R3: A pin held at a steady level sets no flag, whatever its polarity.
- R4: On shared slots 4 to 8, select bit 1 lets the pin set the flag and select bit 0 lets the peripheral event set it. The source that is not selected has no effect on the flag.
- R5: With a slot's peripheral source selected, a peripheral event that is high during one cycle sets the flag at the next rising clock edge.
- R6: A write to the flag register (address 3) clears each flag whose data bit is 0 and leaves each flag whose data bit is 1 unchanged. Writing 1 never sets a flag.
- R7: An acknowledge pulse on a slot clears that slot's flag at the next rising clock edge.
- R8: When a set event and a clear (by write or acknowledge) reach the same slot in the same cycle, the flag ends up set.
- R9: A slot's request line is high exactly when both its flag and its enable bit are 1.
- R10: Register map, bit i for slot i: address 0 holds polarity [8:0], address 1 holds select [8:4] with bits [3:0] reading 0, address 2 holds enable [8:0], address 3 holds flags [8:0]. Bits above 8 read 0, and written values read back through this map.
- R11: A change of a select bit does not clear the slot flag. A request latched from the previous source stays set until software clears it.
- R12: With HAS_HIGH_PINS = 0, pins 6 to 8 have no effect, and select bits 6 to 8 read 0 and stay on the peripheral source even when written with 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| extPin | input | NUM_SLOTS | Asynchronous external interrupt pins |
| periphEvt | input | NUM_SLOTS-SHARED_LO | Peripheral event pulses for shared slots SHARED_LO and up |
| ackIn | input | NUM_SLOTS | Per-slot acknowledge pulses that clear flags |
| regAddr | input | 2 | Register word address |
| regWrEn | input | 1 | Register write strobe |
| regWdata | input | DATA_W | Register write data |
| regRdata | output | DATA_W | Register read data, combinational from regAddr |
| irqReq | output | NUM_SLOTS | Per-slot request lines |

## Verification
The hardest case to reach is the stale request. A flag has to be latched from one source, then the select bit is flipped, and the flag must stay set through the reconfiguration until software clears it. This should happen while the newly selected source is quiet or at a steady level. Directed sequences set up this case and the set-versus-clear collision in chosen cycles, together with pins held steady across a select change. A long random run then toggles pins, peripheral events, acknowledges and register writes against a cycle model of the request flags.

// File: rtl/extirq_pkg.sv
package extirq_pkg;
  localparam int REG_ADDR_W = 2;

  typedef enum logic [REG_ADDR_W-1:0] {
    REG_POL  = 2'd0,
    REG_SEL  = 2'd1,
    REG_ENA  = 2'd2,
    REG_FLAG = 2'd3
  } reg_idx_e;

  typedef struct packed {
    logic     wrPol;
    logic     wrSel;
    logic     wrEna;
    logic     wrFlag;
    reg_idx_e rdIdx;
  } extirq_strobe_t;
endpackage

// File: rtl/extirq_ctrl.sv
module extirq_ctrl
  import extirq_pkg::*;
#(
  parameter int NUM_SLOTS = 9
) (
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic                  regWrEn,
  input  logic [NUM_SLOTS-1:0]  wrBits,
  input  logic [NUM_SLOTS-1:0]  ackIn,
  output extirq_strobe_t        strobe,
  output logic [NUM_SLOTS-1:0]  clrMask
);
  always_comb begin
    strobe       = '0;
    strobe.rdIdx = reg_idx_e'(regAddr);
    if (regWrEn) begin
      unique case (reg_idx_e'(regAddr))
        REG_POL:  strobe.wrPol  = 1'b1;
        REG_SEL:  strobe.wrSel  = 1'b1;
        REG_ENA:  strobe.wrEna  = 1'b1;
        REG_FLAG: strobe.wrFlag = 1'b1;
        default:  ;
      endcase
    end
  end

  // A zero written to the flag register, or an acknowledge, clears the flag.
  always_comb begin
    clrMask = ackIn;
    if (strobe.wrFlag) clrMask = clrMask | ~wrBits;
  end
endmodule

// File: rtl/extirq_edge.sv
module extirq_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinIn,
  input  logic activeHigh,
  output logic edgeHit
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;
  logic                   syncLvl;

  assign syncLvl = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], pinIn};
      prevQ <= syncLvl;
    end
  end

  // Fire once, when the level changes into the selected polarity.
  assign edgeHit = (syncLvl != prevQ) && (syncLvl == activeHigh);
endmodule

// File: rtl/extirq_datapath.sv
module extirq_datapath
  import extirq_pkg::*;
#(
  parameter int NUM_SLOTS     = 9,
  parameter int SHARED_LO     = 4,
  parameter int HIGH_LO       = 6,
  parameter bit HAS_HIGH_PINS = 1'b1,
  parameter int SYNC_STAGES   = 2,
  parameter int DATA_W        = 32
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_SLOTS-1:0]           extPin,
  input  logic [NUM_SLOTS-1:SHARED_LO]   periphEvt,
  input  extirq_strobe_t                 strobe,
  input  logic [NUM_SLOTS-1:0]           wrBits,
  input  logic [NUM_SLOTS-1:0]           clrMask,
  output logic [DATA_W-1:0]              rdData,
  output logic [NUM_SLOTS-1:0]           flagQ,
  output logic [NUM_SLOTS-1:0]           enaQ,
  output logic [NUM_SLOTS-1:0]           slotEvt,
  output logic [NUM_SLOTS-1:0]           irqReq
);
  localparam logic [NUM_SLOTS-1:0] SEL_MASK = {NUM_SLOTS{1'b1}} << SHARED_LO;

  logic [NUM_SLOTS-1:0] polQ;
  logic [NUM_SLOTS-1:0] pinHit;
  logic [NUM_SLOTS-1:0] selEff;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      polQ <= '0;
      enaQ <= '0;
    end else begin
      if (strobe.wrPol) polQ <= wrBits;
      if (strobe.wrEna) enaQ <= wrBits;
    end
  end

  genvar g;
  for (g = 0; g < NUM_SLOTS; g++) begin : g_slot
    if (!HAS_HIGH_PINS && g >= HIGH_LO) begin : g_pin_tied
      logic unusedPin;
      assign unusedPin = extPin[g];
      assign pinHit[g] = 1'b0;
    end else begin : g_pin_live
      extirq_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk       (clk),
        .rstN      (rstN),
        .pinIn     (extPin[g]),
        .activeHigh(polQ[g]),
        .edgeHit   (pinHit[g])
      );
    end

    if (g < SHARED_LO) begin : g_dedicated
      assign selEff[g]  = 1'b1;
      assign slotEvt[g] = pinHit[g];
    end else if (!HAS_HIGH_PINS && g >= HIGH_LO) begin : g_forced
      assign selEff[g]  = 1'b0;
      assign slotEvt[g] = periphEvt[g];
    end else begin : g_shared
      logic selBit;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)            selBit <= 1'b0;
        else if (strobe.wrSel) selBit <= wrBits[g];
      end
      assign selEff[g]  = selBit;
      assign slotEvt[g] = selBit ? pinHit[g] : periphEvt[g];
    end
  end

  // Set has priority over clear in the same cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagQ <= '0;
    else       flagQ <= (flagQ & ~clrMask) | slotEvt;
  end

  assign irqReq = flagQ & enaQ;

  always_comb begin
    rdData = '0;
    unique case (strobe.rdIdx)
      REG_POL:  rdData[NUM_SLOTS-1:0] = polQ;
      REG_SEL:  rdData[NUM_SLOTS-1:0] = selEff & SEL_MASK;
      REG_ENA:  rdData[NUM_SLOTS-1:0] = enaQ;
      REG_FLAG: rdData[NUM_SLOTS-1:0] = flagQ;
      default:  ;
    endcase
  end
endmodule

// File: rtl/extirq_top.sv
module extirq_top
  import extirq_pkg::*;
#(
  parameter int NUM_SLOTS     = 9,
  parameter int SHARED_LO     = 4,
  parameter int HIGH_LO       = 6,
  parameter bit HAS_HIGH_PINS = 1'b1,
  parameter int SYNC_STAGES   = 2,
  parameter int DATA_W        = 32
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_SLOTS-1:0]         extPin,
  input  logic [NUM_SLOTS-1:SHARED_LO] periphEvt,
  input  logic [NUM_SLOTS-1:0]         ackIn,
  input  logic [REG_ADDR_W-1:0]        regAddr,
  input  logic                         regWrEn,
  input  logic [DATA_W-1:0]            regWdata,
  output logic [DATA_W-1:0]            regRdata,
  output logic [NUM_SLOTS-1:0]         irqReq
);
  extirq_strobe_t       strobe;
  logic [NUM_SLOTS-1:0] wrBits;
  logic [NUM_SLOTS-1:0] clrMask;
  logic [NUM_SLOTS-1:0] flagVec;
  logic [NUM_SLOTS-1:0] enaVec;
  logic [NUM_SLOTS-1:0] slotEvt;
  logic                 unusedHiData;

  assign wrBits       = regWdata[NUM_SLOTS-1:0];
  assign unusedHiData = ^regWdata[DATA_W-1:NUM_SLOTS];

  extirq_ctrl #(.NUM_SLOTS(NUM_SLOTS)) u_ctrl (
    .regAddr(regAddr),
    .regWrEn(regWrEn),
    .wrBits (wrBits),
    .ackIn  (ackIn),
    .strobe (strobe),
    .clrMask(clrMask)
  );

  extirq_datapath #(
    .NUM_SLOTS    (NUM_SLOTS),
    .SHARED_LO    (SHARED_LO),
    .HIGH_LO      (HIGH_LO),
    .HAS_HIGH_PINS(HAS_HIGH_PINS),
    .SYNC_STAGES  (SYNC_STAGES),
    .DATA_W       (DATA_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .extPin   (extPin),
    .periphEvt(periphEvt),
    .strobe   (strobe),
    .wrBits   (wrBits),
    .clrMask  (clrMask),
    .rdData   (regRdata),
    .flagQ    (flagVec),
    .enaQ     (enaVec),
    .slotEvt  (slotEvt),
    .irqReq   (irqReq)
  );
endmodule

// File: rtl/extirq_checker.sv
module extirq_checker #(
  parameter int NUM_SLOTS = 9
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_SLOTS-1:0] flagVec,
  input logic [NUM_SLOTS-1:0] enaVec,
  input logic [NUM_SLOTS-1:0] slotEvt,
  input logic [NUM_SLOTS-1:0] clrMask,
  input logic [NUM_SLOTS-1:0] irqReq
);
  // R8: any source event leaves its flag set next cycle, even against a clear.
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    (slotEvt != '0) |=> ((flagVec & $past(slotEvt)) == $past(slotEvt)));

  // R7 (and R6): a clear with no competing event drops the flag.
  p_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((clrMask & ~slotEvt) != '0) |=> ((flagVec & $past(clrMask & ~slotEvt)) == '0));

  // R11: a set flag that nobody clears stays set.
  p_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (flagVec != '0) |=> ((flagVec & $past(flagVec & ~clrMask)) == $past(flagVec & ~clrMask)));

  // R3: no flag rises without a source event.
  p_no_spurious_r3: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> ((flagVec & ~$past(flagVec) & ~$past(slotEvt)) == '0));

  // R9: a request line needs a flag, and nothing requests while all enables are off.
  p_irq_flag_r9: assert property (@(posedge clk) disable iff (!rstN)
    ((irqReq & ~flagVec) == '0));
  p_irq_off_r9: assert property (@(posedge clk) disable iff (!rstN)
    (enaVec == '0) |-> (irqReq == '0));
endmodule

bind extirq_top extirq_checker #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .flagVec(flagVec),
  .enaVec (enaVec),
  .slotEvt(slotEvt),
  .clrMask(clrMask),
  .irqReq (irqReq)
);

// File: tb/extirq_top_bench.sv
module extirq_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 9;
  localparam int SL = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NS-1:0] extPin = '0;
  logic [NS-1:SL] periphEvt = '0;
  logic [NS-1:0] ackIn = '0;
  logic [1:0]    regAddr = '0;
  logic          regWrEn = 1'b0;
  logic [31:0]   regWdata = '0;
  logic [31:0]   regRdata, nRdata;
  logic [NS-1:0] irqReq, nIrq;

  int nCmp = 0;
  int nBad = 0;
  int cyc = 0;
  bit liveCmp = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  extirq_top u_extirq_top (
    .clk(clk), .rstN(rstN), .extPin(extPin), .periphEvt(periphEvt),
    .ackIn(ackIn), .regAddr(regAddr), .regWrEn(regWrEn), .regWdata(regWdata),
    .regRdata(regRdata), .irqReq(irqReq));

  extirq_top #(.HAS_HIGH_PINS(1'b0)) u_narrow (
    .clk(clk), .rstN(rstN), .extPin(extPin), .periphEvt(periphEvt),
    .ackIn(ackIn), .regAddr(regAddr), .regWrEn(regWrEn), .regWdata(regWdata),
    .regRdata(nRdata), .irqReq(nIrq));

  // Cycle model built from the requirements
  logic [NS-1:0] mS1, mS2, mPrev, mPol, mSel, mEn, mFlag;
  logic [NS-1:0] edgeV, evtV, clrV;

  always @(posedge clk) begin
    if (!rstN) begin
      mS1 <= '0; mS2 <= '0; mPrev <= '0;
      mPol <= '0; mSel <= '0; mEn <= '0; mFlag <= '0;
    end else begin
      edgeV = (mS2 ^ mPrev) & ~(mS2 ^ mPol);
      for (int i = 0; i < NS; i++)
        evtV[i] = (i < SL) ? edgeV[i] : (mSel[i] ? edgeV[i] : periphEvt[i]);
      clrV = ackIn | ((regWrEn && regAddr == 2'd3) ? ~regWdata[NS-1:0] : '0);
      mFlag <= (mFlag & ~clrV) | evtV;
      if (regWrEn && regAddr == 2'd0) mPol <= regWdata[NS-1:0];
      if (regWrEn && regAddr == 2'd1) mSel <= regWdata[NS-1:0] & 9'h1F0;
      if (regWrEn && regAddr == 2'd2) mEn  <= regWdata[NS-1:0];
      mS1 <= extPin; mS2 <= mS1; mPrev <= mS2;
    end
  end

  function automatic logic [31:0] expRd(input logic [1:0] a);
    case (a)
      2'd0:    return {23'd0, mPol};
      2'd1:    return {23'd0, mSel};
      2'd2:    return {23'd0, mEn};
      default: return {23'd0, mFlag};
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (liveCmp && rstN) begin
      #3;
      check("R9 request lines vs model", {23'd0, irqReq}, {23'd0, mFlag & mEn});
      check("R10 read data vs model", regRdata, expRd(regAddr));
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    regAddr = a; regWdata = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = regRdata;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      nBad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    process::self().srandom(32'h5eed_1234);
    tick(3);
    rstN = 1'b1;
    tick(1);
    liveCmp = 1'b1;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], d);
      check("R1 reset register", d, 32'd0);
    end
    check("R1 reset request lines", {23'd0, irqReq}, 32'd0);

    // R10 register map readback
    wr(2'd0, 32'hFFFF_FFFF); rd(2'd0, d); check("R10 polarity map", d, 32'h1FF);
    wr(2'd1, 32'hFFFF_FFFF); rd(2'd1, d); check("R10 select map", d, 32'h1F0);
    wr(2'd1, 32'h0);
    wr(2'd2, 32'h1FF);

    // R2 rising edge latency
    extPin[0] = 1'b1;
    tick(2); rd(2'd3, d); check("R2 flag not yet set", d & 32'h1, 32'h0);
    tick(1); rd(2'd3, d); check("R2 flag set on third edge", d & 32'h1, 32'h1);
    check("R9 request with enable", {31'd0, irqReq[0]}, 32'd1);

    // R6 write 0 clears, 1 no effect
    wr(2'd3, 32'h1FE); rd(2'd3, d); check("R6 write-zero clears", d, 32'h0);
    // R3 steady high level
    tick(6); rd(2'd3, d); check("R3 steady level no set", d, 32'h0);
    // R2 falling edge with rising polarity
    extPin[0] = 1'b0; tick(5); rd(2'd3, d); check("R2 wrong direction ignored", d, 32'h0);

    // R2 falling polarity
    wr(2'd0, 32'h1FB);
    extPin[2] = 1'b1; tick(5); rd(2'd3, d); check("R2 rise ignored when falling", d, 32'h0);
    extPin[2] = 1'b0; tick(3); rd(2'd3, d); check("R2 falling edge sets", d & 32'h4, 32'h4);
    wr(2'd3, 32'h0);
    wr(2'd0, 32'h1FF);

    // R7 acknowledge
    extPin[1] = 1'b1; tick(3); rd(2'd3, d); check("R7 setup", d & 32'h2, 32'h2);
    ackIn[1] = 1'b1; tick(1); ackIn[1] = 1'b0; rd(2'd3, d); check("R7 ack clears", d & 32'h2, 32'h0);

    // R5 peripheral event
    periphEvt[4] = 1'b1; tick(1); periphEvt[4] = 1'b0;
    rd(2'd3, d); check("R5 peripheral sets next edge", d & 32'h10, 32'h10);
    wr(2'd3, 32'h0);

    // R4 pin ignored when peripheral selected
    extPin[4] = 1'b1; tick(5); rd(2'd3, d); check("R4 unselected pin ignored", d & 32'h10, 32'h0);
    wr(2'd1, 32'h010);
    tick(4); rd(2'd3, d); check("R3 select change on steady pin", d & 32'h10, 32'h0);
    extPin[4] = 1'b0; tick(4); extPin[4] = 1'b1; tick(3);
    rd(2'd3, d); check("R4 selected pin sets", d & 32'h10, 32'h10);
    wr(2'd3, 32'h0);
    periphEvt[4] = 1'b1; tick(1); periphEvt[4] = 1'b0; tick(1);
    rd(2'd3, d); check("R4 unselected peripheral ignored", d & 32'h10, 32'h0);

    // R8 set wins over ack and over write-clear
    periphEvt[6] = 1'b1; ackIn[6] = 1'b1; tick(1); periphEvt[6] = 1'b0; ackIn[6] = 1'b0;
    rd(2'd3, d); check("R8 set beats ack", d & 32'h40, 32'h40);
    periphEvt[6] = 1'b1; wr(2'd3, 32'h0); periphEvt[6] = 1'b0;
    rd(2'd3, d); check("R8 set beats write clear", d & 32'h40, 32'h40);
    wr(2'd3, 32'h0);

    // R11 stale request across select change
    periphEvt[5] = 1'b1; tick(1); periphEvt[5] = 1'b0;
    wr(2'd1, 32'h030);
    tick(3); rd(2'd3, d); check("R11 stale flag kept", d & 32'h20, 32'h20);
    wr(2'd3, 32'h1DF); rd(2'd3, d); check("R11 cleared by software", d & 32'h20, 32'h0);

    // R9 enable gating
    periphEvt[7] = 1'b1; tick(1); periphEvt[7] = 1'b0;
    wr(2'd2, 32'h0);
    check("R9 disabled slot quiet", {23'd0, irqReq}, 32'd0);
    wr(2'd2, 32'h080);
    check("R9 enabled slot requests", {23'd0, irqReq}, 32'h80);
    wr(2'd3, 32'h0); wr(2'd1, 32'h0);

    // R12 narrow build: pins 6..8 gone, selects forced to peripheral
    wr(2'd1, 32'h1F0);
    regAddr = 2'd1; #1 check("R12 narrow select readback", nRdata, 32'h030);
    wr(2'd3, 32'h0);
    extPin[6] = 1'b1; extPin[8] = 1'b1; tick(4);
    regAddr = 2'd3; #1 check("R12 narrow pins no effect", nRdata & 32'h1C0, 32'h0);
    periphEvt[8] = 1'b1; tick(1); periphEvt[8] = 1'b0;
    regAddr = 2'd3; #1 check("R12 narrow peripheral still works", nRdata & 32'h100, 32'h100);
    wr(2'd3, 32'h0);

    // Random phase
    for (int k = 0; k < 4000; k++) begin
      extPin    = (($urandom % 4) == 0) ? NS'($urandom) : extPin;
      periphEvt = (($urandom % 3) == 0) ? (NS-SL)'($urandom) : '0;
      ackIn     = (($urandom % 5) == 0) ? NS'($urandom) : '0;
      regWrEn   = (($urandom % 6) == 0);
      regAddr   = 2'($urandom);
      regWdata  = $urandom;
      tick(1);
    end
    regWrEn = 1'b0; periphEvt = '0; ackIn = '0;
    tick(2);

    liveCmp = 1'b0;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule